// File: doc/BRIEF.md
# MDIO Multiplexing Management Controller

This block lets a processor run PHY management transactions on any one of several MDIO buses through a small 32-bit register window. The buses are split into an internal group and an external group. One serial engine serves all of them, and a field in the parameter word picks the bus that the engine drives. Software fills in the bus choice, the PHY address, the write data and the frame format, writes the register number (and, for the extended format, the device address) into the address word, and then writes a command code to the control word. The engine shifts the frame out on the selected bus. When the frame is finished it raises a done flag, and it keeps that flag up until software writes zero to the control word.

The controller generates MDC by dividing the system clock by a fixed even ratio. It changes the data line on the falling MDC edge and samples it on the rising edge. The engine takes a copy of the frame fields and the bus choice when a command is accepted, so register writes made during a transaction cannot change the frame on the wire. Buses that are not selected never see a clock edge or a driven data line. Clause-22 frames are sent as a single frame. With the clause-45 select bit set, the engine sends an address frame followed by the write or read frame.

Top module: `mmx_ctrl`

## Requirements
- R1: After reset, every register reads zero, the done flag is 0, every MDC output is low and no data output is enabled.
- R2: Word offsets are parameter 0x00, read data 0x04, address 0x08, control 0x0C and status 0x10. The parameter and address words read back exactly what was written. The read-data word reads zero in bits 31:16. The status word reads zero in bits 31:1.
- R3: Parameter fields: bits 15:0 write data, 20:16 PHY address, 21 clause-45 select, 24:22 bus number, 25 group (1 = internal, 0 = external). When the engine is idle, writing 1 to control starts a write. In clause-22 mode the frame is 32 ones, 01, 01, PHY[4:0], address-word[4:0], 10, data[15:0], sent MSB first and driven for all 64 bits.
- R4: When the engine is idle, writing 2 to control starts a read. The clause-22 frame is 32 ones, 01, 10, PHY, register. The master releases the line for the 2 turnaround bits and the 16 data bits. The sampled bits, MSB first, appear in read data bits 15:0 once done is 1.
- R5: With clause-45 select set, an address frame (32 ones, 00, 00, PHY, address-word[20:16], 10, address-word[15:0]) comes first. It is followed without a gap by a frame with opcode 01 (write, carrying the data) or 11 (read, released from bit 46 on). The same PHY and device fields are used in both frames.
- R6: Status bit 0 becomes 1 after the last bit of the transaction and stays 1 until control is written with 0. That write clears it on the next clock.
- R7: A command written while a transaction runs is ignored. Writes to the parameter or address word during a transaction do not change the frame, its bus or its length.
- R8: Only the bus picked by the group and bus-number fields sees MDC toggles and an enabled data output. All other buses keep MDC low and their data released.
- R9: The MDC period is DIV system clocks. Driven data changes only in the cycle in which MDC falls, apart from the first bit, which appears when the transaction starts.
- R10: Writing 0 to control during a transaction aborts it. In the next cycle all MDC outputs are low and all data outputs are released, and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc_int | output | NUM_BUS | MDC per internal bus |
| mdo_int | output | NUM_BUS | Data out per internal bus |
| mdoe_int | output | NUM_BUS | Data output enable per internal bus |
| mdi_int | input | NUM_BUS | Data in per internal bus |
| mdc_ext | output | NUM_BUS | MDC per external bus |
| mdo_ext | output | NUM_BUS | Data out per external bus |
| mdoe_ext | output | NUM_BUS | Data output enable per external bus |
| mdi_ext | input | NUM_BUS | Data in per external bus |

## Verification
If the bit counter or the shift register is wrong, the first bad or missing bit shows up at the next rising MDC edge of the target bus. A whole frame of recorded bits is compared for every transaction. If the captured bus selection is wrong, clock or enable activity appears on another bus at the very first MDC edge, and a check made on every cycle catches it. A fault in the done flag or in the abort path shows in the status word or on the MDC lines one clock after the control write.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    localparam int unsigned FRAME_BITS = 64;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_WR   = 2'd1,
        CMD_RD   = 2'd2
    } cmd_e;

    localparam logic [2:0] W_PARAM = 3'd0;
    localparam logic [2:0] W_RDATA = 3'd1;
    localparam logic [2:0] W_ADDR  = 3'd2;
    localparam logic [2:0] W_CTRL  = 3'd3;
    localparam logic [2:0] W_STAT  = 3'd4;

    typedef struct packed {
        logic [1:0]  spare_hi;
        logic        cyc_mark;
        logic [2:0]  spare_mid;
        logic        grp_int;
        logic [2:0]  bus_num;
        logic        ext_fmt;
        logic [4:0]  phy;
        logic [15:0] wdata;
    } param_t;

    function automatic logic [FRAME_BITS-1:0] frame_basic(
        input logic        rd,
        input logic [4:0]  phy,
        input logic [4:0]  regn,
        input logic [15:0] data
    );
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regn,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : data)};
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_ext(
        input logic [1:0]  op,
        input logic        rd,
        input logic [4:0]  phy,
        input logic [4:0]  dev,
        input logic [15:0] payload
    );
        return {32'hFFFF_FFFF, 2'b00, op, phy, dev,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : payload)};
    endfunction

endpackage

// File: rtl/mmx_regs.sv
module mmx_regs
    import mmx_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic [15:0]       rx,
    output logic              start,
    output logic              abort,
    output logic              op_rd,
    output param_t            param,
    output logic [31:0]       addr_word,
    output logic              done
);

    localparam int unsigned WIDX_W = ADDR_W - 2;

    typedef struct packed {
        param_t      param;
        logic [31:0] addr;
        logic [1:0]  ctrl;
        logic        done;
        logic        rd_op;
        logic [15:0] rdat;
    } regs_t;

    regs_t q, d;

    logic [WIDX_W-1:0] widx;
    logic              ctrl_hit;
    logic              cmd_ok;

    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        ctrl_hit = we && (widx == WIDX_W'(W_CTRL));
        cmd_ok   = (wdata[31:2] == '0) &&
                   ((wdata[1:0] == CMD_WR) || (wdata[1:0] == CMD_RD));
        start    = ctrl_hit && cmd_ok && !busy;
        abort    = ctrl_hit && (wdata == 32'd0);
    end

    always_comb begin
        d = q;
        if (we && (widx == WIDX_W'(W_PARAM))) d.param = param_t'(wdata);
        if (we && (widx == WIDX_W'(W_ADDR)))  d.addr  = wdata;
        if (fin) begin
            d.done = 1'b1;
            if (q.rd_op) d.rdat = rx;
        end
        if (start) begin
            d.ctrl  = wdata[1:0];
            d.rd_op = (wdata[1:0] == CMD_RD);
            d.done  = 1'b0;
        end
        if (abort) begin
            d.ctrl = CMD_IDLE;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (widx)
            WIDX_W'(W_PARAM): rdata = q.param;
            WIDX_W'(W_RDATA): rdata = {16'd0, q.rdat};
            WIDX_W'(W_ADDR):  rdata = q.addr;
            WIDX_W'(W_CTRL):  rdata = {30'd0, q.ctrl};
            WIDX_W'(W_STAT):  rdata = {31'd0, q.done};
            default:          rdata = '0;
        endcase
    end

    assign op_rd     = (wdata[1:0] == CMD_RD);
    assign param     = q.param;
    assign addr_word = q.addr;
    assign done      = q.done;

endmodule

// File: rtl/mmx_engine.sv
module mmx_engine
    import mmx_pkg::*;
#(
    parameter int unsigned DIV = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        abort,
    input  logic        op_rd,
    input  logic        ext_fmt,
    input  logic [4:0]  phy,
    input  logic [4:0]  regn,
    input  logic [4:0]  dev,
    input  logic [15:0] reg16,
    input  logic [15:0] wdata,
    input  logic        din,
    output logic        mdc,
    output logic        dout,
    output logic        doe,
    output logic        busy,
    output logic        fin,
    output logic [15:0] rx
);

    localparam int unsigned HALF  = DIV / 2;
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [5:0]  TA_POS   = 6'd46;
    localparam logic [5:0]  DATA_POS = 6'd48;
    localparam logic [5:0]  LAST_POS = 6'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  run;
        logic [CNT_W-1:0]      cnt;
        logic                  mdc;
        logic [5:0]            bitn;
        logic                  rd;
        logic                  last;
        logic [FRAME_BITS-1:0] sh;
        logic [FRAME_BITS-1:0] nxt;
        logic [15:0]           rx;
        logic                  fin;
    } eng_t;

    eng_t q, d;
    logic rise, fall;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        rise  = 1'b0;
        fall  = 1'b0;
        if (q.run) begin
            if (q.cnt == CNT_W'(HALF - 1)) begin
                d.cnt = '0;
                d.mdc = ~q.mdc;
                rise  = ~q.mdc;
                fall  = q.mdc;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            if (rise && q.rd && q.last && (q.bitn >= DATA_POS))
                d.rx = {q.rx[14:0], din};
            if (fall) begin
                d.sh   = {q.sh[FRAME_BITS-2:0], 1'b1};
                d.bitn = q.bitn + 1'b1;
                if (q.bitn == LAST_POS) begin
                    if (!q.last) begin
                        d.sh   = q.nxt;
                        d.last = 1'b1;
                    end else begin
                        d.run = 1'b0;
                        d.fin = 1'b1;
                    end
                end
            end
        end
        if (abort) begin
            d.run = 1'b0;
            d.mdc = 1'b0;
            d.cnt = '0;
        end else if (start && !q.run) begin
            d.run  = 1'b1;
            d.cnt  = '0;
            d.mdc  = 1'b0;
            d.bitn = '0;
            d.rd   = op_rd;
            d.last = !ext_fmt;
            d.sh   = ext_fmt ? frame_ext(2'b00, 1'b0, phy, dev, reg16)
                             : frame_basic(op_rd, phy, regn, wdata);
            d.nxt  = frame_ext(op_rd ? 2'b11 : 2'b01, op_rd, phy, dev, wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc  = q.mdc;
    assign dout = q.sh[FRAME_BITS-1];
    assign doe  = q.run && !(q.rd && q.last && (q.bitn >= TA_POS));
    assign busy = q.run;
    assign fin  = q.fin;
    assign rx   = q.rx;

endmodule

// File: rtl/mmx_busfan.sv
module mmx_busfan #(
    parameter int unsigned NUM_BUS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               grp_int,
    input  logic [2:0]         bus_num,
    input  logic               mdc,
    input  logic               dout,
    input  logic               doe,
    output logic [NUM_BUS-1:0] mdc_int,
    output logic [NUM_BUS-1:0] mdo_int,
    output logic [NUM_BUS-1:0] mdoe_int,
    input  logic [NUM_BUS-1:0] mdi_int,
    output logic [NUM_BUS-1:0] mdc_ext,
    output logic [NUM_BUS-1:0] mdo_ext,
    output logic [NUM_BUS-1:0] mdoe_ext,
    input  logic [NUM_BUS-1:0] mdi_ext,
    output logic               din
);

    typedef struct packed {
        logic       grp;
        logic [2:0] num;
    } sel_t;

    sel_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.grp = grp_int;
            d.num = bus_num;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < NUM_BUS; i++) begin : g_lane
        logic hit_i, hit_e;
        assign hit_i       = q.grp  && (q.num == 3'(i));
        assign hit_e       = !q.grp && (q.num == 3'(i));
        assign mdc_int[i]  = hit_i & mdc;
        assign mdoe_int[i] = hit_i & doe;
        assign mdo_int[i]  = hit_i & doe & dout;
        assign mdc_ext[i]  = hit_e & mdc;
        assign mdoe_ext[i] = hit_e & doe;
        assign mdo_ext[i]  = hit_e & doe & dout;
    end

    always_comb begin
        din = 1'b1;
        for (int i = 0; i < NUM_BUS; i++) begin
            if (q.num == 3'(i)) din = q.grp ? mdi_int[i] : mdi_ext[i];
        end
    end

endmodule

// File: rtl/mmx_ctrl.sv
module mmx_ctrl
    import mmx_pkg::*;
#(
    parameter int unsigned NUM_BUS = 8,
    parameter int unsigned DIV     = 20,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_BUS-1:0] mdc_int,
    output logic [NUM_BUS-1:0] mdo_int,
    output logic [NUM_BUS-1:0] mdoe_int,
    input  logic [NUM_BUS-1:0] mdi_int,
    output logic [NUM_BUS-1:0] mdc_ext,
    output logic [NUM_BUS-1:0] mdo_ext,
    output logic [NUM_BUS-1:0] mdoe_ext,
    input  logic [NUM_BUS-1:0] mdi_ext
);

    logic        start_w, abort_w, op_rd_w, done_w;
    logic        busy_w, fin_w;
    logic        mdc_w, dout_w, doe_w, din_w;
    logic [15:0] rx_w;
    logic [31:0] addr_w;
    param_t      param_w;

    mmx_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (busy_w),
        .fin       (fin_w),
        .rx        (rx_w),
        .start     (start_w),
        .abort     (abort_w),
        .op_rd     (op_rd_w),
        .param     (param_w),
        .addr_word (addr_w),
        .done      (done_w)
    );

    mmx_engine #(.DIV(DIV)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .abort   (abort_w),
        .op_rd   (op_rd_w),
        .ext_fmt (param_w.ext_fmt),
        .phy     (param_w.phy),
        .regn    (addr_w[4:0]),
        .dev     (addr_w[20:16]),
        .reg16   (addr_w[15:0]),
        .wdata   (param_w.wdata),
        .din     (din_w),
        .mdc     (mdc_w),
        .dout    (dout_w),
        .doe     (doe_w),
        .busy    (busy_w),
        .fin     (fin_w),
        .rx      (rx_w)
    );

    mmx_busfan #(.NUM_BUS(NUM_BUS)) u_fan (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_w),
        .grp_int  (param_w.grp_int),
        .bus_num  (param_w.bus_num),
        .mdc      (mdc_w),
        .dout     (dout_w),
        .doe      (doe_w),
        .mdc_int  (mdc_int),
        .mdo_int  (mdo_int),
        .mdoe_int (mdoe_int),
        .mdi_int  (mdi_int),
        .mdc_ext  (mdc_ext),
        .mdo_ext  (mdo_ext),
        .mdoe_ext (mdoe_ext),
        .mdi_ext  (mdi_ext),
        .din      (din_w)
    );

endmodule

// File: rtl/mmx_ctrl_chk.sv
module mmx_ctrl_chk #(
    parameter int unsigned NUM_BUS = 8,
    parameter int unsigned ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               done,
    input logic               busy,
    input logic [NUM_BUS-1:0] mdc_int,
    input logic [NUM_BUS-1:0] mdoe_int,
    input logic [NUM_BUS-1:0] mdc_ext,
    input logic [NUM_BUS-1:0] mdoe_ext
);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(5'h0C));

    // R8
    a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mdc_int, mdc_ext}));

    // R8
    a_r8_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mdoe_int, mdoe_ext}));

    // R6
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (reg_wdata == 32'd0)) |=> !done);

    // R6
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ctrl_wr) |=> done);

    // R10
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (({mdc_int, mdc_ext} == '0) && ({mdoe_int, mdoe_ext} == '0)));

endmodule

bind mmx_ctrl mmx_ctrl_chk #(.NUM_BUS(NUM_BUS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .done      (done_w),
    .busy      (busy_w),
    .mdc_int   (mdc_int),
    .mdoe_int  (mdoe_int),
    .mdc_ext   (mdc_ext),
    .mdoe_ext  (mdoe_ext)
);

// File: tb/mmx_ctrl_tb.sv
module mmx_ctrl_tb;

    localparam int NB  = 8;
    localparam int DIV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NB-1:0] mdc_int, mdo_int, mdoe_int, mdi_int;
    logic [NB-1:0] mdc_ext, mdo_ext, mdoe_ext, mdi_ext;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic       tgt_int = 1'b1;
    logic [2:0] tgt_id  = 3'd0;
    logic       tb_din  = 1'b1;

    always #10 clk = ~clk;

    assign mdi_int = tgt_int  ? ({{(NB-1){1'b0}}, tb_din} << tgt_id) : '0;
    assign mdi_ext = !tgt_int ? ({{(NB-1){1'b0}}, tb_din} << tgt_id) : '0;

    mmx_ctrl #(.NUM_BUS(NB), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc_int(mdc_int), .mdo_int(mdo_int), .mdoe_int(mdoe_int), .mdi_int(mdi_int),
        .mdc_ext(mdc_ext), .mdo_ext(mdo_ext), .mdoe_ext(mdoe_ext), .mdi_ext(mdi_ext)
    );

    // line monitor and PHY model
    logic    rec_b [128];
    logic    rec_oe[128];
    int      idx = 0, last_rise = -1, cyc = 0;
    int      period_bad = 0, edge_bad = 0, quiet_bad = 0;
    int      rd_base = 1000;
    logic [15:0] rd_val = '0;
    logic    p_mdc = 0, p_o = 0, p_oe = 0;
    logic    m_mdc, m_o, m_oe;
    logic [2*NB-1:0] tmask;

    always_comb begin
        m_mdc = tgt_int ? mdc_int[tgt_id]  : mdc_ext[tgt_id];
        m_o   = tgt_int ? mdo_int[tgt_id]  : mdo_ext[tgt_id];
        m_oe  = tgt_int ? mdoe_int[tgt_id] : mdoe_ext[tgt_id];
        tmask = tgt_int ? ({{NB{1'b0}}, {(NB-1){1'b0}}, 1'b1} << (NB + 32'(tgt_id)))
                        : ({{NB{1'b0}}, {(NB-1){1'b0}}, 1'b1} << tgt_id);
    end

    always @(negedge clk) begin
        cyc++;
        if ((({mdc_int, mdc_ext} | {mdoe_int, mdoe_ext}) & ~tmask) != '0) quiet_bad++;
        if (!p_mdc && m_mdc) begin
            if (idx < 128) begin
                rec_b[idx]  = m_o;
                rec_oe[idx] = m_oe;
            end
            if (last_rise >= 0 && (cyc - last_rise) != DIV) period_bad++;
            last_rise = cyc;
            idx++;
        end
        if (p_mdc && !m_mdc) begin
            if (idx >= rd_base && idx < rd_base + 16) tb_din = rd_val[15 - (idx - rd_base)];
            else tb_din = 1'b1;
        end
        if (m_oe && p_oe && (m_o != p_o) && !(p_mdc && !m_mdc)) edge_bad++;
        p_mdc = m_mdc;
        p_o   = m_o;
        p_oe  = m_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        int k;
        for (k = 0; k < 20000; k++) begin
            rd(5'h10, s);
            if (s[0]) break;
        end
        check(req, 32'(k < 20000), 32'd1);
    endtask

    task automatic mon_clear(input logic gi, input logic [2:0] id, input int base,
                             input logic [15:0] rv);
        @(negedge clk);
        tgt_int = gi; tgt_id = id;
        idx = 0; last_rise = -1; period_bad = 0; edge_bad = 0; quiet_bad = 0;
        rd_base = base; rd_val = rv;
        for (int i = 0; i < 128; i++) begin rec_b[i] = 1'bx; rec_oe[i] = 1'bx; end
    endtask

    function automatic logic [31:0] mkp(input logic gi, input logic [2:0] id, input logic c45,
                                        input logic [4:0] phy, input logic [15:0] data);
        return {6'd0, gi, id, c45, phy, data};
    endfunction

    // compare recorded bits; mask bit set = driven bit expected
    task automatic cmp_frame(input string req, input int nbits,
                             input logic [127:0] e, input logic [127:0] m);
        int bad = 0;
        for (int i = 0; i < nbits; i++) begin
            if (m[127-i]) begin
                if (rec_oe[i] !== 1'b1 || rec_b[i] !== e[127-i]) bad++;
            end else if (rec_oe[i] !== 1'b0) bad++;
        end
        check({req, " frame bits"}, bad, 0);
        check({req, " bit count"}, idx, nbits);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int w = 0; w < 5; w++) begin
            rd(5'(w * 4), v);
            check("R1 reg after reset", v, 0);
        end
        check("R1 lines idle", {16'd0, mdc_int, mdc_ext}, 0);
        check("R1 no drivers", {16'd0, mdoe_int, mdoe_ext}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(5'h00, 32'hDEAD_BEEF);
        rd(5'h00, v); check("R2 param readback", v, 32'hDEAD_BEEF);
        wr(5'h08, 32'h1234_5678);
        rd(5'h08, v); check("R2 addr readback", v, 32'h1234_5678);
        rd(5'h04, v); check("R2 rdata upper zero", v, 0);
        rd(5'h10, v); check("R2 status idle", v, 0);
        check("R2 nothing started", {16'd0, mdc_int, mdc_ext}, 0);
    endtask

    task automatic t_write22();
        logic [127:0] e, m;
        mon_clear(1'b1, 3'd3, 1000, 16'h0);
        wr(5'h00, mkp(1'b1, 3'd3, 1'b0, 5'h05, 16'hBEEF));
        wr(5'h08, 32'h0000_001A);
        wr(5'h0C, 32'd1);
        wait_done("R3 write done");
        e = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h1A, 2'b10, 16'hBEEF, 64'd0};
        m = {64'hFFFF_FFFF_FFFF_FFFF, 64'd0};
        cmp_frame("R3", 64, e, m);
        check("R8 other buses quiet", quiet_bad, 0);
        check("R9 mdc period", period_bad, 0);
        check("R9 data on falling edge", edge_bad, 0);
        wr(5'h0C, 32'd0);
    endtask

    task automatic t_read22();
        logic [127:0] e, m;
        logic [31:0] v;
        mon_clear(1'b0, 3'd6, 48, 16'h5A3C);
        wr(5'h00, mkp(1'b0, 3'd6, 1'b0, 5'h11, 16'h0));
        wr(5'h08, 32'h0000_0002);
        wr(5'h0C, 32'd2);
        wait_done("R4 read done");
        e = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h11, 5'h02, 18'd0, 64'd0};
        m = {46'h3FFF_FFFF_FFFF, 18'd0, 64'd0};
        cmp_frame("R4", 64, e, m);
        rd(5'h04, v); check("R4 read data", v, 32'h0000_5A3C);
        check("R8 external bus only", quiet_bad, 0);
        wr(5'h0C, 32'd0);
    endtask

    task automatic t_read45();
        logic [127:0] e, m;
        logic [31:0] v;
        mon_clear(1'b1, 3'd0, 112, 16'hC0DE);
        wr(5'h00, mkp(1'b1, 3'd0, 1'b1, 5'h1F, 16'h0));
        wr(5'h08, {11'd0, 5'h07, 16'hA55A});
        wr(5'h0C, 32'd2);
        wait_done("R5 ext read done");
        e = {32'hFFFF_FFFF, 2'b00, 2'b00, 5'h1F, 5'h07, 2'b10, 16'hA55A,
             32'hFFFF_FFFF, 2'b00, 2'b11, 5'h1F, 5'h07, 18'd0};
        m = {64'hFFFF_FFFF_FFFF_FFFF, 46'h3FFF_FFFF_FFFF, 18'd0};
        cmp_frame("R5", 128, e, m);
        rd(5'h04, v); check("R5 read data", v, 32'h0000_C0DE);
        check("R9 period across frames", period_bad, 0);
        wr(5'h0C, 32'd0);
    endtask

    task automatic t_write45();
        logic [127:0] e, m;
        mon_clear(1'b0, 3'd2, 1000, 16'h0);
        wr(5'h00, mkp(1'b0, 3'd2, 1'b1, 5'h03, 16'h0F0F));
        wr(5'h08, {11'd0, 5'h1E, 16'h0102});
        wr(5'h0C, 32'd1);
        wait_done("R5 ext write done");
        e = {32'hFFFF_FFFF, 2'b00, 2'b00, 5'h03, 5'h1E, 2'b10, 16'h0102,
             32'hFFFF_FFFF, 2'b00, 2'b01, 5'h03, 5'h1E, 2'b10, 16'h0F0F};
        m = '1;
        cmp_frame("R5 write", 128, e, m);
        wr(5'h0C, 32'd0);
    endtask

    task automatic t_busy_ignore();
        logic [127:0] e, m;
        mon_clear(1'b1, 3'd2, 1000, 16'h0);
        wr(5'h00, mkp(1'b1, 3'd2, 1'b0, 5'h01, 16'h1234));
        wr(5'h08, 32'h3);
        wr(5'h0C, 32'd1);
        repeat (200) @(negedge clk);
        wr(5'h00, mkp(1'b0, 3'd5, 1'b1, 5'h1C, 16'hFFFF));
        wr(5'h08, 32'h0011_0019);
        wr(5'h0C, 32'd2);
        wait_done("R7 done");
        e = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h01, 5'h03, 2'b10, 16'h1234, 64'd0};
        m = {64'hFFFF_FFFF_FFFF_FFFF, 64'd0};
        cmp_frame("R7", 64, e, m);
        check("R7 bus unchanged", quiet_bad, 0);
    endtask

    task automatic t_done_level();
        logic [31:0] v;
        repeat (100) @(negedge clk);
        rd(5'h10, v); check("R6 done held", v, 1);
        wr(5'h0C, 32'd0);
        rd(5'h10, v); check("R6 done cleared", v, 0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        mon_clear(1'b0, 3'd1, 48, 16'h0);
        wr(5'h00, mkp(1'b0, 3'd1, 1'b0, 5'h02, 16'h0));
        wr(5'h08, 32'h4);
        wr(5'h0C, 32'd2);
        repeat (300) @(negedge clk);
        check("R10 running before abort", {31'd0, mdoe_ext[1]}, 1);
        wr(5'h0C, 32'd0);
        check("R10 mdc low", {16'd0, mdc_int, mdc_ext}, 0);
        check("R10 released", {16'd0, mdoe_int, mdoe_ext}, 0);
        repeat (200) @(negedge clk);
        rd(5'h10, v); check("R10 done stays 0", v, 0);
        check("R10 stays quiet", {16'd0, mdc_int, mdc_ext, mdoe_int, mdoe_ext} == 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_write22();
        t_read22();
        t_read45();
        t_write45();
        t_busy_ignore();
        t_done_level();
        t_abort();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule